// File: doc/BRIEF.md
# Hybrid Redundancy Switch-Voter

This block sits behind a pool of identical, redundant modules. It masks a faulty module and retires it. There are three active modules and `S` spares. A switch picks three of the `3+S` module output words and passes them to a word-level majority voter. The voted word is the block's result. In the same cycle, each active word is compared against the vote. An active module whose word differs from the majority is marked failed, and the lowest-numbered spare not yet used takes its slot.

When every spare has been brought in, the block stops reconfiguring and acts as fixed triple modular redundancy. A single bad module is then still outvoted. If the three active words all differ, the block raises a no-majority flag and leaves the configuration unchanged. Besides the voted word, the outputs report which module drives each slot, which modules have been retired, and whether the spare pool is empty.

Top module: `hybrid_switch_voter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the block shows the following state. Slot s holds module s for s = 0, 1, 2. `failed_mask` is zero, `voted` is zero and `no_majority` is low. `spares_exhausted` is high only when S = 0.
- R2: `voted` is registered. After the clock edge that samples the inputs, it shows the value that at least two of the three active words share.
- R3: Suppose a majority exists and one active word differs from it, while spares remain. At that same edge the dissenting slot is given the next spare, and the retired module's bit in `failed_mask` is set. With three inputs and a majority, at most one active word can dissent, so at most one slot is replaced per cycle.
- R4: If all three active words differ, `no_majority` goes high after the edge and `voted` takes slot 0's word. The slot mapping and `failed_mask` do not change.
- R5: Spares are used in ascending module index (3, then 4, and so on). A module whose bit in `failed_mask` is set stays set and never drives a slot again. A retired module's data has no effect on any output.
- R6: `spares_exhausted` is high exactly when S modules are marked failed. From then on, a dissenting word is still outvoted, and the mapping and mask stay unchanged.
- R7: When all three active words are equal, the mapping and mask are unchanged and `no_majority` is low.
- R8: The module index for slot s sits in `slot_map[s*IDXW +: IDXW]`, where IDXW = $clog2(3+S). The three slots always name three distinct modules.
- R9: The word of module m sits in `mod_data[m*W +: W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_data | input | (3+S)*W | Output words of all modules, module m at bits m*W |
| voted | output | W | Registered majority word |
| no_majority | output | 1 | Registered flag: the three active words all differed |
| slot_map | output | 3*IDXW | Module index driving each active slot |
| failed_mask | output | 3+S | One bit per module that has been retired |
| spares_exhausted | output | 1 | All spares have been consumed |

## Verification
The bench builds the block with W = 8 and S = 2, giving five modules. With two spares, both replacements can be driven one after the other. The bench can then reach the exhausted state and see that further dissent is only masked. It also checks that a retired module's garbage data stays invisible, and it places no-majority cycles both before and after exhaustion.

// File: rtl/hsv_pkg.sv
package hsv_pkg;

    localparam int ACTIVE = 3;

    typedef enum logic [1:0] {
        VOTE_UNANIMOUS = 2'd0,
        VOTE_DISSENT   = 2'd1,
        VOTE_SPLIT     = 2'd2
    } vote_kind_e;

    // index of the lowest set bit of a three-bit slot vector (0 when none)
    function automatic logic [1:0] lowest_slot(input logic [2:0] m);
        logic [1:0] r;
        r = 2'd0;
        if (m[0])      r = 2'd0;
        else if (m[1]) r = 2'd1;
        else if (m[2]) r = 2'd2;
        return r;
    endfunction

endpackage

// File: rtl/hsv_slot_mux.sv
module hsv_slot_mux #(
    parameter int W     = 16,
    parameter int N_MOD = 5,
    parameter int IDXW  = 3
) (
    input  logic [N_MOD*W-1:0]              mod_data,
    input  logic [hsv_pkg::ACTIVE*IDXW-1:0] slot_map,
    output logic [W-1:0]                    slot_word [hsv_pkg::ACTIVE]
);
    for (genvar s = 0; s < hsv_pkg::ACTIVE; s++) begin : g_slot
        logic [IDXW-1:0] sel;
        assign sel = slot_map[s*IDXW +: IDXW];
        always_comb begin
            slot_word[s] = '0;
            for (int m = 0; m < N_MOD; m++) begin
                if (sel == IDXW'(m)) slot_word[s] = mod_data[m*W +: W];
            end
        end
    end
endmodule

// File: rtl/hsv_word_voter.sv
module hsv_word_voter #(
    parameter int W = 16
) (
    input  logic [W-1:0]       slot_word [hsv_pkg::ACTIVE],
    output logic [W-1:0]       vote,
    output hsv_pkg::vote_kind_e kind,
    output logic [2:0]         dissent
);
    logic eq01, eq02, eq12;

    assign eq01 = (slot_word[0] == slot_word[1]);
    assign eq02 = (slot_word[0] == slot_word[2]);
    assign eq12 = (slot_word[1] == slot_word[2]);

    always_comb begin
        if (eq01 || eq02)      vote = slot_word[0];
        else if (eq12)         vote = slot_word[1];
        else                   vote = slot_word[0];

        if (eq01 && eq02)              kind = hsv_pkg::VOTE_UNANIMOUS;
        else if (eq01 || eq02 || eq12) kind = hsv_pkg::VOTE_DISSENT;
        else                           kind = hsv_pkg::VOTE_SPLIT;

        dissent = '0;
        if (kind == hsv_pkg::VOTE_DISSENT) begin
            for (int s = 0; s < hsv_pkg::ACTIVE; s++)
                dissent[s] = (slot_word[s] != vote);
        end
    end
endmodule

// File: rtl/hsv_spare_ctrl.sv
module hsv_spare_ctrl #(
    parameter int N_MOD = 5,
    parameter int IDXW  = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [2:0]                      dissent,
    output logic [hsv_pkg::ACTIVE*IDXW-1:0] slot_map,
    output logic [N_MOD-1:0]                failed_mask,
    output logic                            exhausted
);
    localparam int CW = $clog2(N_MOD + 1);

    logic [IDXW-1:0] map_q [hsv_pkg::ACTIVE];
    logic [CW-1:0]   next_q;
    logic [N_MOD-1:0] failed_q;
    logic            can_swap;
    logic [1:0]      victim;

    assign exhausted = (next_q == CW'(N_MOD));
    assign can_swap  = (|dissent) && !exhausted;
    assign victim    = hsv_pkg::lowest_slot(dissent);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < hsv_pkg::ACTIVE; s++) map_q[s] <= IDXW'(s);
            next_q   <= CW'(hsv_pkg::ACTIVE);
            failed_q <= '0;
        end else if (can_swap) begin
            failed_q[map_q[victim]] <= 1'b1;
            map_q[victim]           <= IDXW'(next_q);
            next_q                  <= next_q + CW'(1);
        end
    end

    for (genvar s = 0; s < hsv_pkg::ACTIVE; s++) begin : g_flat
        assign slot_map[s*IDXW +: IDXW] = map_q[s];
    end
    assign failed_mask = failed_q;
endmodule

// File: rtl/hybrid_switch_voter.sv
module hybrid_switch_voter #(
    parameter  int W     = 16,
    parameter  int S     = 2,
    localparam int N_MOD = hsv_pkg::ACTIVE + S,
    localparam int IDXW  = $clog2(N_MOD)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_MOD*W-1:0]    mod_data,
    output logic [W-1:0]          voted,
    output logic                  no_majority,
    output logic [3*IDXW-1:0]     slot_map,
    output logic [N_MOD-1:0]      failed_mask,
    output logic                  spares_exhausted
);
    logic [W-1:0]        slot_word [hsv_pkg::ACTIVE];
    logic [W-1:0]        vote;
    hsv_pkg::vote_kind_e kind;
    logic [2:0]          dissent;

    hsv_slot_mux #(.W(W), .N_MOD(N_MOD), .IDXW(IDXW)) mux_i (
        .mod_data (mod_data),
        .slot_map (slot_map),
        .slot_word(slot_word)
    );

    hsv_word_voter #(.W(W)) voter_i (
        .slot_word(slot_word),
        .vote     (vote),
        .kind     (kind),
        .dissent  (dissent)
    );

    hsv_spare_ctrl #(.N_MOD(N_MOD), .IDXW(IDXW)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .dissent    (dissent),
        .slot_map   (slot_map),
        .failed_mask(failed_mask),
        .exhausted  (spares_exhausted)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            voted       <= '0;
            no_majority <= 1'b0;
        end else begin
            voted       <= vote;
            no_majority <= (kind == hsv_pkg::VOTE_SPLIT);
        end
    end
endmodule

// File: rtl/hsv_checker.sv
module hsv_checker #(
    parameter int S     = 2,
    parameter int N_MOD = 5,
    parameter int IDXW  = 3
) (
    input logic                clk,
    input logic                rst,
    input logic [3*IDXW-1:0]   slot_map,
    input logic [N_MOD-1:0]    failed_mask,
    input logic                spares_exhausted,
    input logic                no_majority
);
    // R5: retired modules stay retired
    assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (($past(failed_mask) & ~failed_mask) == '0));

    // R3: at most one module retired per edge
    assert_one_swap_R3: assert property (@(posedge clk) disable iff (rst)
        ($countones(failed_mask ^ $past(failed_mask)) <= 1));

    // R4: a split vote leaves the configuration alone
    assert_split_holds_R4: assert property (@(posedge clk) disable iff (rst)
        no_majority |-> (slot_map == $past(slot_map) && failed_mask == $past(failed_mask)));

    // R6: exhaustion flag tracks the number of retired modules
    assert_exhaust_count_R6: assert property (@(posedge clk) disable iff (rst)
        (spares_exhausted == ($countones(failed_mask) == S)));

    // R8: slots name distinct modules
    assert_distinct_slots_R8: assert property (@(posedge clk) disable iff (rst)
        (slot_map[0 +: IDXW] != slot_map[IDXW +: IDXW]) &&
        (slot_map[0 +: IDXW] != slot_map[2*IDXW +: IDXW]) &&
        (slot_map[IDXW +: IDXW] != slot_map[2*IDXW +: IDXW]));

    // R5: no active slot is driven by a retired module
    for (genvar s = 0; s < 3; s++) begin : g_live
        assert_active_healthy_R5: assert property (@(posedge clk) disable iff (rst)
            !failed_mask[slot_map[s*IDXW +: IDXW]]);
    end
endmodule

bind hybrid_switch_voter hsv_checker #(.S(S), .N_MOD(N_MOD), .IDXW(IDXW)) chk_i (
    .clk             (clk),
    .rst             (rst),
    .slot_map        (slot_map),
    .failed_mask     (failed_mask),
    .spares_exhausted(spares_exhausted),
    .no_majority     (no_majority)
);

// File: tb/hybrid_switch_voter_tb_top.sv
module hybrid_switch_voter_tb_top;
    localparam int W     = 8;
    localparam int S     = 2;
    localparam int N_MOD = 3 + S;
    localparam int IDXW  = $clog2(N_MOD);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [N_MOD*W-1:0]   mod_data = '0;
    logic [W-1:0]         voted;
    logic                 no_majority;
    logic [3*IDXW-1:0]    slot_map;
    logic [N_MOD-1:0]     failed_mask;
    logic                 spares_exhausted;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    // reference model state
    int mmap [3];
    int mfail [N_MOD];
    int mnext;
    int exp_voted;
    int exp_nomaj;

    always #10 clk = ~clk;

    hybrid_switch_voter #(.W(W), .S(S)) dut_i (
        .clk(clk), .rst(rst), .mod_data(mod_data), .voted(voted),
        .no_majority(no_majority), .slot_map(slot_map),
        .failed_mask(failed_mask), .spares_exhausted(spares_exhausted)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_map();
        return mmap[0] | (mmap[1] << IDXW) | (mmap[2] << (2*IDXW));
    endfunction

    function automatic int model_fail();
        int r = 0;
        for (int m = 0; m < N_MOD; m++) if (mfail[m] != 0) r |= (1 << m);
        return r;
    endfunction

    task automatic compare_all(input string tag);
        int cnt = 0;
        for (int m = 0; m < N_MOD; m++) cnt += mfail[m];
        check(tag, "voted", int'(voted), exp_voted);
        check(tag, "no_majority", int'(no_majority), exp_nomaj);
        check(tag, "slot_map", int'(slot_map), model_map());
        check(tag, "failed_mask", int'(failed_mask), model_fail());
        check(tag, "spares_exhausted", int'(spares_exhausted), (cnt == S) ? 1 : 0);
    endtask

    // drive one cycle of module words, advance the model, compare after the edge
    task automatic step(input int v0, input int v1, input int v2, input int v3,
                        input int v4, input string tag);
        int v [N_MOD];
        int a, b, c, vote, dis;
        @(negedge clk);
        v[0] = v0; v[1] = v1; v[2] = v2; v[3] = v3; v[4] = v4;
        for (int m = 0; m < N_MOD; m++) mod_data[m*W +: W] = W'(v[m]);
        a = v[mmap[0]]; b = v[mmap[1]]; c = v[mmap[2]];
        dis = -1;
        if (a == b && a == c) begin
            vote = a; exp_nomaj = 0;
        end else if (a == b) begin
            vote = a; exp_nomaj = 0; dis = 2;
        end else if (a == c) begin
            vote = a; exp_nomaj = 0; dis = 1;
        end else if (b == c) begin
            vote = b; exp_nomaj = 0; dis = 0;
        end else begin
            vote = a; exp_nomaj = 1;
        end
        exp_voted = vote;
        if (dis >= 0 && mnext < N_MOD) begin
            mfail[mmap[dis]] = 1;
            mmap[dis] = mnext;
            mnext++;
        end
        @(posedge clk);
        #2;
        compare_all(tag);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        for (int s = 0; s < 3; s++) mmap[s] = s;
        for (int m = 0; m < N_MOD; m++) mfail[m] = 0;
        mnext = 3;
        exp_voted = 0;
        exp_nomaj = 0;
        repeat (3) @(posedge clk);
        #2;
        compare_all("R1");
        @(negedge clk);
        rst = 1'b0;
        #1;
        compare_all("R1");

        // R2 / R7: unanimous words
        step(8'h11, 8'h11, 8'h11, 8'h11, 8'h11, "R2");
        step(8'hA5, 8'hA5, 8'hA5, 8'h00, 8'h00, "R7");
        step(8'hFF, 8'hFF, 8'hFF, 8'h3C, 8'hC3, "R2");
        step(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, "R7");

        // R3: module 1 dissents, spare 3 takes slot 1
        step(8'h5A, 8'h77, 8'h5A, 8'h5A, 8'h5A, "R3");
        // R5 / R9: retired module 1 emits garbage, no effect
        step(8'h5A, 8'hE1, 8'h5A, 8'h5A, 8'h5A, "R5");
        step(8'h42, 8'h99, 8'h42, 8'h42, 8'h42, "R9");

        // R4: all three active words differ
        step(8'h01, 8'h55, 8'h03, 8'h02, 8'h07, "R4");

        // R3 / R5: slot 0 module 0 dissents, spare 4 comes in, pool empty
        step(8'h13, 8'h00, 8'h6E, 8'h6E, 8'h6E, "R5");
        step(8'h13, 8'h00, 8'h6E, 8'h6E, 8'h6E, "R6");

        // R6: after exhaustion dissent is only masked
        step(8'h00, 8'h00, 8'hBB, 8'h2D, 8'h2D, "R6");
        step(8'h00, 8'h00, 8'h2D, 8'h90, 8'h2D, "R6");
        step(8'h00, 8'h00, 8'h2D, 8'h2D, 8'h81, "R6");

        // R4 after exhaustion
        step(8'h00, 8'h00, 8'h10, 8'h20, 8'h30, "R4");
        // R8: mapping stays distinct under unanimity
        step(8'h44, 8'h44, 8'h77, 8'h77, 8'h77, "R8");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    always @(posedge clk) cycles++;
endmodule